// File: doc/BRIEF.md
# Shared-Pin GPIO Port with Function Select

This block controls one I/O port of up to `PORT_W` pins. Each pin is shared between general-purpose I/O and two on-chip peripherals, a primary one and an alternate one. A 2-bit function field for each pin chooses which of the three drives the pad. In GPIO mode the pad is driven from an output latch and a direction bit. In a peripheral mode the output enable and the output value come straight from that peripheral. The block also passes per-pin slew and drive-strength controls to the pad.

Software reaches the registers over a simple synchronous bus. A write takes effect at the clock edge. A read is combinational while the bus is selected and the write strobe is low. The latch has two atomic views besides plain writes. One view sets the latch bits written as 1. The other clears the latch bits written as 0. The pin-state view returns the pad levels after a two-flop synchroniser, and the same synchronised level is forwarded to the selected peripheral. Only the lowest `NUM_USED` pins are implemented.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset every register reads 0, and every pad has output enable 0, output 0, slew 0 and drive 0.
- R2: A pin whose function field is 00 or 11 is GPIO. In this mode, pad output enable equals its direction bit (1 = output) and pad output equals its latch bit.
- R3: A read of address 2 returns the pad input levels as they were two clock edges earlier. It does not return the latch.
- R4: A write to address 2 sets each latch bit written as 1 and leaves each bit written as 0 unchanged.
- R5: A write to address 3 clears each latch bit written as 0 and leaves each bit written as 1 unchanged. A read of address 3 returns 0.
- R6: The function field of pin i is at bits [2i+1:2i] of address 4. Value 01 makes the pad output enable and output equal to the primary peripheral's, and the direction bit is ignored.
- R7: Function value 10 makes the pad output enable and output equal to the alternate peripheral's.
- R8: The primary input of a pin equals its synchronised pad level when its field is 01 and is 0 otherwise. The alternate input behaves the same way for field value 10.
- R9: Addresses 5 (slew) and 6 (drive strength, 1 = high) are readable and writable, and each bit appears unchanged on its pad-control output.
- R10: Pins at index NUM_USED and above ignore every write, read back 0, and keep pad output enable and output at 0.
- R11: Address 0 holds the output latch and address 1 the direction bits. Each reads back the value last written to it, restricted to the implemented pins. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register address |
| busWdata | input | 2*PORT_W | Write data |
| busRdata | output | 2*PORT_W | Read data, 0 when not reading |
| padIn | input | PORT_W | Level seen at each pad |
| padOe | output | PORT_W | Pad output enable |
| padOut | output | PORT_W | Pad output value |
| padSlew | output | PORT_W | Pad slew-rate control |
| padDrive | output | PORT_W | Pad drive-strength control |
| priOe | input | PORT_W | Primary peripheral output enable |
| priOut | input | PORT_W | Primary peripheral output value |
| priIn | output | PORT_W | Synchronised pad level to primary peripheral |
| altOe | input | PORT_W | Alternate peripheral output enable |
| altOut | input | PORT_W | Alternate peripheral output value |
| altIn | output | PORT_W | Synchronised pad level to alternate peripheral |

## Verification
The bench uses a port with six of its eight pins implemented. Three sweeps cover the latch. Every 8-bit value is written to the latch, which shows the masking of unimplemented pins and the path from latch to pad. Paired set and clear patterns show that the two atomic views differ in polarity and that neither touches the bits written with the opposite value. A pattern that differs from the latch is driven onto input pads, which shows that the pin-state view reads the pads and not the latch, with a two-edge delay. All four function codes are tried on every pin, with distinct peripheral patterns and the direction bit set. This separates GPIO, primary, alternate and the reserved code in both the pad outputs and the returned peripheral inputs.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  typedef enum logic [1:0] {
    FN_GPIO = 2'b00,
    FN_PRI  = 2'b01,
    FN_ALT  = 2'b10,
    FN_RSVD = 2'b11
  } fnSel_t;

  typedef enum logic [2:0] {
    RA_LATCH  = 3'd0,
    RA_DIR    = 3'd1,
    RA_PINSET = 3'd2,
    RA_CLEAR  = 3'd3,
    RA_FUNC   = 3'd4,
    RA_SLEW   = 3'd5,
    RA_DRIVE  = 3'd6,
    RA_NONE   = 3'd7
  } regAddr_t;

  typedef struct packed {
    logic     wrLatch;
    logic     wrDir;
    logic     wrSet;
    logic     wrClr;
    logic     wrFunc;
    logic     wrSlew;
    logic     wrDrive;
    logic     rdEn;
    regAddr_t rdSel;
  } strobe_t;

endpackage

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
(
  input  logic       busSel,
  input  logic       busWr,
  input  logic [2:0] busAddr,
  output strobe_t    stb
);

  regAddr_t addrSel;
  logic     wrAct;

  assign addrSel = regAddr_t'(busAddr);
  assign wrAct   = busSel & busWr;

  always_comb begin
    stb       = '0;
    stb.rdEn  = busSel & ~busWr;
    stb.rdSel = addrSel;
    case (addrSel)
      RA_LATCH:  stb.wrLatch = wrAct;
      RA_DIR:    stb.wrDir   = wrAct;
      RA_PINSET: stb.wrSet   = wrAct;
      RA_CLEAR:  stb.wrClr   = wrAct;
      RA_FUNC:   stb.wrFunc  = wrAct;
      RA_SLEW:   stb.wrSlew  = wrAct;
      RA_DRIVE:  stb.wrDrive = wrAct;
      default:   ;
    endcase
  end

endmodule

// File: rtl/gpio_mux_sync.sv
module gpio_mux_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end

endmodule

// File: rtl/gpio_mux_dp.sv
module gpio_mux_dp
  import gpio_mux_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int NUM_USED = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [2*PORT_W-1:0]   busWdata,
  output logic [2*PORT_W-1:0]   busRdata,
  input  logic [PORT_W-1:0]     padIn,
  output logic [PORT_W-1:0]     padOe,
  output logic [PORT_W-1:0]     padOut,
  output logic [PORT_W-1:0]     padSlew,
  output logic [PORT_W-1:0]     padDrive,
  input  logic [PORT_W-1:0]     priOe,
  input  logic [PORT_W-1:0]     priOut,
  output logic [PORT_W-1:0]     priIn,
  input  logic [PORT_W-1:0]     altOe,
  input  logic [PORT_W-1:0]     altOut,
  output logic [PORT_W-1:0]     altIn,
  output logic [PORT_W-1:0]     latchQ,
  output logic [2*PORT_W-1:0]   funcQ
);

  localparam int FW = 2 * PORT_W;
  localparam logic [PORT_W-1:0] USED_MASK = {PORT_W{1'b1}} >> (PORT_W - NUM_USED);
  localparam logic [FW-1:0]     FUNC_MASK = {FW{1'b1}} >> (2 * (PORT_W - NUM_USED));

  logic [PORT_W-1:0] wrByte;
  logic [PORT_W-1:0] dirQ, slewQ, driveQ;
  logic [PORT_W-1:0] pinSync, pinLevel;

  assign wrByte = busWdata[PORT_W-1:0] & USED_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
    end else if (stb.wrLatch) begin
      latchQ <= wrByte;
    end else if (stb.wrSet) begin
      latchQ <= latchQ | wrByte;
    end else if (stb.wrClr) begin
      latchQ <= latchQ & (busWdata[PORT_W-1:0] | ~USED_MASK);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ   <= '0;
      slewQ  <= '0;
      driveQ <= '0;
      funcQ  <= '0;
    end else begin
      if (stb.wrDir)   dirQ   <= wrByte;
      if (stb.wrSlew)  slewQ  <= wrByte;
      if (stb.wrDrive) driveQ <= wrByte;
      if (stb.wrFunc)  funcQ  <= busWdata & FUNC_MASK;
    end
  end

  gpio_mux_sync #(.W(PORT_W)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (padIn),
    .dout (pinSync)
  );

  assign pinLevel = pinSync & USED_MASK;

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    fnSel_t fn;
    assign fn        = fnSel_t'(funcQ[2*i +: 2]);
    assign padOe[i]  = (fn == FN_PRI) ? priOe[i]  : (fn == FN_ALT) ? altOe[i]  : dirQ[i];
    assign padOut[i] = (fn == FN_PRI) ? priOut[i] : (fn == FN_ALT) ? altOut[i] : latchQ[i];
    assign priIn[i]  = (fn == FN_PRI) & pinLevel[i];
    assign altIn[i]  = (fn == FN_ALT) & pinLevel[i];
  end

  assign padSlew  = slewQ;
  assign padDrive = driveQ;

  always_comb begin
    busRdata = '0;
    if (stb.rdEn) begin
      case (stb.rdSel)
        RA_LATCH:  busRdata = {{PORT_W{1'b0}}, latchQ};
        RA_DIR:    busRdata = {{PORT_W{1'b0}}, dirQ};
        RA_PINSET: busRdata = {{PORT_W{1'b0}}, pinLevel};
        RA_FUNC:   busRdata = funcQ;
        RA_SLEW:   busRdata = {{PORT_W{1'b0}}, slewQ};
        RA_DRIVE:  busRdata = {{PORT_W{1'b0}}, driveQ};
        default:   busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int NUM_USED = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [2:0]          busAddr,
  input  logic [2*PORT_W-1:0] busWdata,
  output logic [2*PORT_W-1:0] busRdata,
  input  logic [PORT_W-1:0]   padIn,
  output logic [PORT_W-1:0]   padOe,
  output logic [PORT_W-1:0]   padOut,
  output logic [PORT_W-1:0]   padSlew,
  output logic [PORT_W-1:0]   padDrive,
  input  logic [PORT_W-1:0]   priOe,
  input  logic [PORT_W-1:0]   priOut,
  output logic [PORT_W-1:0]   priIn,
  input  logic [PORT_W-1:0]   altOe,
  input  logic [PORT_W-1:0]   altOut,
  output logic [PORT_W-1:0]   altIn
);

  strobe_t             stb;
  logic [PORT_W-1:0]   latchQ;
  logic [2*PORT_W-1:0] funcQ;

  gpio_mux_ctrl u_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .stb     (stb)
  );

  gpio_mux_dp #(.PORT_W(PORT_W), .NUM_USED(NUM_USED)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOe    (padOe),
    .padOut   (padOut),
    .padSlew  (padSlew),
    .padDrive (padDrive),
    .priOe    (priOe),
    .priOut   (priOut),
    .priIn    (priIn),
    .altOe    (altOe),
    .altOut   (altOut),
    .altIn    (altIn),
    .latchQ   (latchQ),
    .funcQ    (funcQ)
  );

endmodule

// File: rtl/gpio_mux_chk.sv
module gpio_mux_chk #(
  parameter int PORT_W   = 8,
  parameter int NUM_USED = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWr,
  input logic [2:0]          busAddr,
  input logic [2*PORT_W-1:0] busRdata,
  input logic [PORT_W-1:0]   padIn,
  input logic [PORT_W-1:0]   padOe,
  input logic [PORT_W-1:0]   padOut,
  input logic [PORT_W-1:0]   priOe,
  input logic [PORT_W-1:0]   priOut,
  input logic [PORT_W-1:0]   altOe,
  input logic [PORT_W-1:0]   altOut,
  input logic [PORT_W-1:0]   latchQ,
  input logic [2*PORT_W-1:0] funcQ
);

  localparam logic [PORT_W-1:0] USED_MASK = {PORT_W{1'b1}} >> (PORT_W - NUM_USED);

  logic [1:0] sinceReset;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end

  AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == 3'd2) |=> ((latchQ & $past(latchQ)) == $past(latchQ))); // R4

  AST_CLR_NEVER_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == 3'd3) |=> ((latchQ & ~$past(latchQ)) == '0)); // R5

  AST_PINSET_TWO_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 2'd2 && busSel && !busWr && busAddr == 3'd2)
      |-> (busRdata[PORT_W-1:0] == ($past(padIn, 2) & USED_MASK))); // R3

  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (((padOe | padOut) & ~USED_MASK) == '0)); // R10

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    AST_PRI_OWNS_PAD: assert property (@(posedge clk) disable iff (!rstN)
      (funcQ[2*i +: 2] == 2'b01) |-> (padOe[i] == priOe[i] && padOut[i] == priOut[i])); // R6
    AST_ALT_OWNS_PAD: assert property (@(posedge clk) disable iff (!rstN)
      (funcQ[2*i +: 2] == 2'b10) |-> (padOe[i] == altOe[i] && padOut[i] == altOut[i])); // R7
    AST_GPIO_FROM_LATCH: assert property (@(posedge clk) disable iff (!rstN)
      (funcQ[2*i +: 2] == 2'b00 || funcQ[2*i +: 2] == 2'b11) |-> (padOut[i] == latchQ[i])); // R2
  end

endmodule

bind gpio_mux_port gpio_mux_chk #(.PORT_W(PORT_W), .NUM_USED(NUM_USED)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .padIn    (padIn),
  .padOe    (padOe),
  .padOut   (padOut),
  .priOe    (priOe),
  .priOut   (priOut),
  .altOe    (altOe),
  .altOut   (altOut),
  .latchQ   (latchQ),
  .funcQ    (funcQ)
);

// File: tb/sim_gpio_mux_port.sv
`timescale 1ns/1ps
module sim_gpio_mux_port;

  localparam int PW   = 8;
  localparam int USED = 6;
  localparam logic [7:0] MASK = 8'h3F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [7:0]  padIn, padOe, padOut, padSlew, padDrive;
  logic [7:0]  priOe = '0, priOut = '0, altOe = '0, altOut = '0;
  logic [7:0]  priIn, altIn;
  logic [7:0]  ext = '0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  assign padIn = (padOe & padOut) | (~padOe & ext);

  gpio_mux_port #(.PORT_W(PW), .NUM_USED(USED)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .padOe(padOe),
    .padOut(padOut), .padSlew(padSlew), .padDrive(padDrive), .priOe(priOe),
    .priOut(priOut), .priIn(priIn), .altOe(altOe), .altOut(altOut), .altIn(altIn)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), r);
      chk("R1 reset readback", r, 16'h0);
    end
    chk("R1 reset padOe", {8'h0, padOe}, 16'h0);
    chk("R1 reset padOut", {8'h0, padOut}, 16'h0);
    chk("R1 reset pad control", {padSlew, padDrive}, 16'h0);

    // R11/R2/R10: latch sweep with all outputs, then all inputs
    wr(3'd1, 16'h00FF);
    rd(3'd1, r);
    chk("R11 dir readback masked", r, 16'h003F);
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, 16'(v));
      rd(3'd0, r);
      chk("R11 latch readback", r, {8'h0, 8'(v) & MASK});
      chk("R2 gpio padOut", {8'h0, padOut}, {8'h0, 8'(v) & MASK});
      chk("R10 unused pads quiet", {8'h0, padOe}, 16'h003F);
    end
    wr(3'd1, 16'h0005);
    chk("R2 padOe follows dir", {8'h0, padOe}, 16'h0005);
    rd(3'd7, r);
    chk("R11 unused address", r, 16'h0);

    // R4/R5: set and clear sweeps
    for (int a = 0; a < 64; a++) begin
      logic [7:0] b;
      b = 8'((a * 29 + 7) & 255);
      wr(3'd0, 16'(a));
      wr(3'd2, {8'h0, b});
      rd(3'd0, r);
      chk("R4 set view", r, {8'h0, (8'(a) | b) & MASK});
      wr(3'd0, 16'(a));
      wr(3'd3, {8'h0, b});
      rd(3'd0, r);
      chk("R5 clear view", r, {8'h0, 8'(a) & b & MASK});
      rd(3'd3, r);
      chk("R5 clear reads zero", r, 16'h0);
    end

    // R3: pin-state view reads pads, not latch
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0015);
    for (int p = 0; p < 256; p += 7) begin
      @(negedge clk);
      ext = 8'(p);
      @(negedge clk);
      rd(3'd2, r);
      chk("R3 pin state after two edges", r, {8'h0, 8'(p) & MASK});
    end
    @(negedge clk);
    ext = 8'h2A;
    rd(3'd2, r);
    chk("R3 pin state one edge later still old", r, {8'h0, 8'hFC & MASK});
    rd(3'd2, r);
    chk("R3 pin state differs from latch", r, 16'h002A);

    // R6/R7/R8/R2: every function code on every pin
    priOe = 8'hFF; priOut = 8'h2A; altOe = 8'hFF; altOut = 8'h15;
    ext = 8'h3F;
    wr(3'd0, 16'h0000);
    for (int i = 0; i < USED; i++) begin
      for (int f = 0; f < 4; f++) begin
        logic eOe, eOut, pin;
        wr(3'd1, 16'(1 << i));
        wr(3'd4, 16'(f << (2 * i)));
        rd(3'd4, r);
        chk("R6 field position", r, 16'(f << (2 * i)));
        eOe  = (f == 1) ? priOe[i]  : (f == 2) ? altOe[i]  : 1'b1;
        eOut = (f == 1) ? priOut[i] : (f == 2) ? altOut[i] : 1'b0;
        pin  = eOe ? eOut : ext[i];
        chk(f == 2 ? "R7 pad oe" : (f == 1 ? "R6 pad oe" : "R2 pad oe"), {15'h0, padOe[i]}, {15'h0, eOe});
        chk(f == 2 ? "R7 pad out" : (f == 1 ? "R6 pad out" : "R2 pad out"), {15'h0, padOut[i]}, {15'h0, eOut});
        repeat (3) @(negedge clk);
        chk("R8 primary input", {15'h0, priIn[i]}, {15'h0, (f == 1) & pin});
        chk("R8 alternate input", {15'h0, altIn[i]}, {15'h0, (f == 2) & pin});
      end
    end
    // R6: direction ignored in primary mode
    wr(3'd4, 16'h0001);
    wr(3'd1, 16'h0000);
    priOe = 8'h01;
    chk("R6 direction ignored", {15'h0, padOe[0]}, 16'h0001);

    // R10: unused fields ignored
    wr(3'd4, 16'hFFFF);
    rd(3'd4, r);
    chk("R10 function field masked", r, 16'h0FFF);
    chk("R10 unused pad oe", {14'h0, padOe[7:6]}, 16'h0);
    wr(3'd4, 16'h0000);

    // R9: pad control pass-through
    for (int v = 0; v < 256; v += 17) begin
      wr(3'd5, 16'(v));
      wr(3'd6, 16'(255 - v));
      chk("R9 slew pad", {8'h0, padSlew}, {8'h0, 8'(v) & MASK});
      chk("R9 drive pad", {8'h0, padDrive}, {8'h0, 8'(255 - v) & MASK});
      rd(3'd5, r);
      chk("R9 slew readback", r, {8'h0, 8'(v) & MASK});
      rd(3'd6, r);
      chk("R9 drive readback", r, {8'h0, 8'(255 - v) & MASK});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule